// File: doc/BRIEF.md
# Ones' Complement Pair Adder

This block adds two unsigned words in ones' complement arithmetic, the operation at the core of internet-style checksums. On each clock where the input strobe is high, it captures the sum of the two operands and presents it, with a valid flag, one cycle later. A checksum engine built around it can feed one new operand pair every cycle. That engine would add the accumulation across a packet and the final inversion.

The end-around carry costs no second addition. Each operand pair is laid out twice at double width, as {a,b} and {b,a}, and the two are added in one adder. The low half of that addition produces the carry out of a+b, and it ripples straight into the high half, where a+b is formed again. The high half is therefore the ordinary sum with the carry already folded back in at bit 0. The word width is a parameter and defaults to 16 bits.

Top module: `ones_comp_adder`

## Requirements
- R1: While rst_n is low, out_vld is 0 and out_sum is 0.
- R2: out_vld is high on exactly the cycle that follows a rising clock edge at which in_vld was high.
- R3: On the cycle after in_vld is sampled high, out_sum equals the low WIDTH bits of in_a+in_b, plus 1 when that addition carries out of bit WIDTH-1.
- R4: The result does not depend on operand order: swapping in_a and in_b gives the same out_sum.
- R5: Adding the all-ones word (0xFFFF at default width) to a non-zero operand returns that operand. Adding it to 0x0000 gives 0xFFFF, the negative zero.
- R6: An operand added to its bitwise complement always gives the all-ones word.
- R7: While in_vld is low, out_sum keeps its last value.
- R8: Operand pairs may arrive on consecutive cycles, and each one gets its own result one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Operand pair strobe |
| in_a | input | WIDTH | First operand |
| in_b | input | WIDTH | Second operand |
| out_vld | output | 1 | Result valid, one cycle after in_vld |
| out_sum | output | WIDTH | Ones' complement sum, held while idle |

## Verification
The checker assumes that in_vld, in_a and in_b are stable around the rising edge, and that they are known values whenever in_vld is high. The bench drives every input on the falling edge, so each value is settled half a period before it is sampled. The bench holds in_vld low throughout reset, so no operand pair is pending when reset is released. Random pairs mix with directed all-ones, zero, complement and carry-boundary operands, and idle gaps test the hold rule.

// File: rtl/ones_comp_pkg.sv
package ones_comp_pkg;

    // Default operand width of the adder
    localparam int unsigned OCA_DEFAULT_W = 16;

endpackage

// File: rtl/oca_operand_pair.sv
// Forms the two double-width adder inputs: {a,b} and {b,a}.
module oca_operand_pair #(
    parameter int unsigned WIDTH = 16,
    localparam int unsigned WW   = 2 * WIDTH
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    output logic [WW-1:0]    pair_ab,
    output logic [WW-1:0]    pair_ba
);

    always_comb begin
        pair_ab = {op_a, op_b};
        pair_ba = {op_b, op_a};
    end

endmodule

// File: rtl/oca_wide_add.sv
// One double-width adder; the upper half carries the folded-in carry.
module oca_wide_add #(
    parameter int unsigned WIDTH = 16,
    localparam int unsigned WW   = 2 * WIDTH
) (
    input  logic [WW-1:0]    add_x,
    input  logic [WW-1:0]    add_y,
    output logic [WIDTH-1:0] upper
);

    always_comb begin
        upper = WIDTH'((add_x + add_y) >> WIDTH);
    end

endmodule

// File: rtl/ones_comp_adder.sv
module ones_comp_adder
    import ones_comp_pkg::*;
#(
    parameter int unsigned WIDTH = OCA_DEFAULT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_vld,
    input  logic [WIDTH-1:0] in_a,
    input  logic [WIDTH-1:0] in_b,
    output logic             out_vld,
    output logic [WIDTH-1:0] out_sum
);

    localparam int unsigned WW = 2 * WIDTH;

    typedef struct packed {
        logic             vld;
        logic [WIDTH-1:0] sum;
    } oca_state_t;

    oca_state_t state_d, state_q;

    logic [WW-1:0]    pair_ab;
    logic [WW-1:0]    pair_ba;
    logic [WIDTH-1:0] folded;

    oca_operand_pair #(.WIDTH(WIDTH)) u_pair (
        .op_a    (in_a),
        .op_b    (in_b),
        .pair_ab (pair_ab),
        .pair_ba (pair_ba)
    );

    oca_wide_add #(.WIDTH(WIDTH)) u_add (
        .add_x (pair_ab),
        .add_y (pair_ba),
        .upper (folded)
    );

    always_comb begin
        state_d     = state_q;
        state_d.vld = in_vld;
        if (in_vld) begin
            state_d.sum = folded;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_vld = state_q.vld;
    assign out_sum = state_q.sum;

endmodule

// File: rtl/ones_comp_adder_chk.sv
module ones_comp_adder_chk #(
    parameter int unsigned WIDTH = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_vld,
    input logic [WIDTH-1:0] in_a,
    input logic [WIDTH-1:0] in_b,
    input logic             out_vld,
    input logic [WIDTH-1:0] out_sum
);

    function automatic logic [WIDTH-1:0] fold_sum(input logic [WIDTH-1:0] a,
                                                  input logic [WIDTH-1:0] b);
        logic [WIDTH:0] t;
        t = {1'b0, a} + {1'b0, b};
        return t[WIDTH-1:0] + {{(WIDTH-1){1'b0}}, t[WIDTH]};
    endfunction

    a_r2_vld_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_vld);

    a_r2_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> !out_vld);

    a_r3_folded_sum: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> (out_sum == $past(fold_sum(in_a, in_b))));

    a_r6_complement_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && (in_a == ~in_b)) |=> (out_sum == {WIDTH{1'b1}}));

    a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> $stable(out_sum));

endmodule

bind ones_comp_adder ones_comp_adder_chk #(.WIDTH(WIDTH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_vld  (in_vld),
    .in_a    (in_a),
    .in_b    (in_b),
    .out_vld (out_vld),
    .out_sum (out_sum)
);

// File: tb/ones_comp_adder_test.sv
module ones_comp_adder_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_vld = 1'b0;
    logic [15:0] in_a = '0;
    logic [15:0] in_b = '0;
    logic        out_vld;
    logic [15:0] out_sum;

    int unsigned n_run  = 0;
    int unsigned n_fail = 0;
    bit          done   = 1'b0;

    logic        exp_vld = 1'b0;
    logic [15:0] exp_sum = '0;
    logic        pend    = 1'b0;
    string       pend_tag = "";

    always #10 clk = ~clk;

    ones_comp_adder #(.WIDTH(16)) uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (in_vld),
        .in_a    (in_a),
        .in_b    (in_b),
        .out_vld (out_vld),
        .out_sum (out_sum)
    );

    function automatic logic [15:0] ref_sum(input logic [15:0] a, input logic [15:0] b);
        logic [16:0] t;
        t = {1'b0, a} + {1'b0, b};
        return t[15:0] + {15'd0, t[16]};
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // On a falling edge: check the result of the previous step, then drive the next.
    task automatic step(input logic v, input logic [15:0] a, input logic [15:0] b,
                        input string tag);
        @(negedge clk);
        if (pend) begin
            check({pend_tag, " R2 valid"}, {15'd0, out_vld}, {15'd0, exp_vld});
            check({pend_tag, " sum"}, out_sum, exp_sum);
        end
        in_vld = v;
        in_a   = a;
        in_b   = b;
        exp_vld = v;
        if (v) exp_sum = ref_sum(a, b);
        pend     = 1'b1;
        pend_tag = tag;
    endtask

    initial begin
        logic [15:0] sa;
        logic [15:0] sb;
        logic [15:0] s1;
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset valid", {15'd0, out_vld}, 16'd0);
        check("R1 reset sum", out_sum, 16'd0);
        rst_n = 1'b1;

        // R3: plain sums, with and without carry
        step(1'b1, 16'h1234, 16'h4321, "R3 no carry");
        step(1'b1, 16'h8000, 16'h8000, "R3 carry boundary");
        step(1'b1, 16'hFFFE, 16'h0003, "R3 carry wrap");
        // R5: all-ones identity and negative zero
        step(1'b1, 16'h5A5A, 16'hFFFF, "R5 identity");
        step(1'b1, 16'h0001, 16'hFFFF, "R5 identity small");
        step(1'b1, 16'h0000, 16'hFFFF, "R5 negative zero");
        step(1'b1, 16'hFFFF, 16'hFFFF, "R5 both ones");
        step(1'b1, 16'h0000, 16'h0000, "R3 zero zero");
        // R6: complement pairs
        step(1'b1, 16'hA5C3, 16'h5A3C, "R6 complement");
        step(1'b1, 16'h0F0F, 16'hF0F0, "R6 complement b");
        // R7: idle gaps must hold the last result
        step(1'b0, 16'h1111, 16'h2222, "R7 hold 1");
        step(1'b0, 16'hFFFF, 16'h0001, "R7 hold 2");
        // R4: order independence
        step(1'b1, 16'hC001, 16'h7FFF, "R4 order ab");
        @(negedge clk);
        check("R4 order ab sum", out_sum, ref_sum(16'hC001, 16'h7FFF));
        s1 = out_sum;
        pend = 1'b0;
        in_vld = 1'b1; in_a = 16'h7FFF; in_b = 16'hC001;
        @(negedge clk);
        check("R4 order ba sum", out_sum, s1);
        in_vld = 1'b0;

        // R8: back-to-back random pairs, with occasional gaps
        for (int i = 0; i < 400; i++) begin
            sa = 16'($urandom);
            sb = 16'($urandom);
            if ((i % 7) == 3) sb = ~sa;
            step(($urandom % 5) != 0, sa, sb, "R8 random");
        end
        step(1'b0, 16'h0, 16'h0, "R7 final hold");
        step(1'b0, 16'h0, 16'h0, "R7 final hold 2");
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule